// File: doc/BRIEF.md
# Operand Effective-Address Generator

This unit sits between instruction decode and the load/store path of a simple load/store processor. Each request carries a 3-bit addressing-mode code, two register values already read from the register file (a base and an index), and the 16-bit field taken from the instruction word. The unit produces one 32-bit result. For the two non-memory modes this result is the operand value itself. For the four memory modes it is the effective address.

Alongside the result, the unit reports three flags. One says whether a memory access is needed. One marks a memory address that is not on a 4-byte boundary. One marks a mode code that is not defined. All outputs are registered. They appear exactly one clock after the request strobe and stay unchanged until the next request. The unit does not read the register file and does not perform the memory access.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 0 (immediate): one clock after the strobe, the result is the 16-bit field sign-extended to 32 bits, and the memory flag is 0.
- R2: Mode code 1 (register): the result is the base value, and the memory flag is 0.
- R3: Mode code 2 (absolute): the result is the 16-bit field sign-extended to 32 bits, and the memory flag is 1.
- R4: Mode code 3 (register indirect): the result is the base value, and the memory flag is 1.
- R5: Mode code 4 (indexed): the result is the base value plus the sign-extended 16-bit field, modulo 2^32, and the memory flag is 1.
- R6: Mode code 5 (base plus index): the result is the base value plus the index value, modulo 2^32, and the memory flag is 1.
- R7: The misalignment flag is 1 exactly when the memory flag is 1 and bits [1:0] of the result are not both zero. For the non-memory modes it is 0.
- R8: Mode codes 6 and 7 set the illegal-mode flag and give a result of 0, a memory flag of 0 and a misalignment flag of 0. The illegal-mode flag is 0 for every other code.
- R9: The output-valid pulse is high in exactly the one cycle after each cycle in which the input strobe is high, and low otherwise. After reset every output is 0.
- R10: While the strobe is low, the result and all three flags keep their values, whatever the mode, register and field inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing-mode code (0 to 5 defined) |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| ifield | input | 16 | Instruction constant field |
| out_valid | output | 1 | High one clock after a request |
| result | output | 32 | Operand value or effective address |
| mem_access | output | 1 | Memory access required |
| align_err | output | 1 | Memory address not 4-byte aligned |
| illegal_mode | output | 1 | Undefined mode code |

## Verification
The assertions assume the mode, register and field inputs are stable and known in every cycle where the strobe is high. They assume nothing about those inputs while the strobe is low. The stimulus therefore sets all request inputs at the same falling edge that raises the strobe. Between requests it deliberately drives changing values on the idle inputs, which exercises the hold property. The field values are chosen so that the sign bit takes both values, the additions wrap past 2^32, and the low address bits cover both the aligned and the misaligned cases.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  localparam int DATA_W  = 32;
  localparam int FIELD_W = 16;
  localparam int MODE_W  = 3;
  localparam int ALIGN_BITS = 2;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM = 3'd0,
    AM_REG = 3'd1,
    AM_ABS = 3'd2,
    AM_IND = 3'd3,
    AM_IDX = 3'd4,
    AM_BIX = 3'd5
  } amode_e;

  typedef struct packed {
    logic [DATA_W-1:0] value;
    logic              mem;
    logic              misalign;
    logic              illegal;
  } ea_res_t;

  // Sign-extend the instruction field to the full data width.
  function automatic logic [DATA_W-1:0] sext_field(input logic [FIELD_W-1:0] f);
    return {{(DATA_W-FIELD_W){f[FIELD_W-1]}}, f};
  endfunction

  // Modular address sum; carry out is discarded.
  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic low_bits_set(input logic [DATA_W-1:0] a);
    return |a[ALIGN_BITS-1:0];
  endfunction
endpackage

// File: rtl/opaddr_sext.sv
module opaddr_sext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
    end else begin : g_trunc
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/opaddr_calc.sv
module opaddr_calc
  import opaddr_pkg::*;
(
  input  logic [MODE_W-1:0]  mode,
  input  logic [DATA_W-1:0]  base_val,
  input  logic [DATA_W-1:0]  index_val,
  input  logic [FIELD_W-1:0] ifield,
  output logic [DATA_W-1:0]  ext_field,
  output logic [DATA_W-1:0]  sum_off,
  output logic [DATA_W-1:0]  sum_pair,
  output ea_res_t            res
);
  opaddr_sext #(.IN_W(FIELD_W), .OUT_W(DATA_W)) u_sext (
    .din  (ifield),
    .dout (ext_field)
  );

  assign sum_off  = wrap_add(base_val, ext_field);
  assign sum_pair = wrap_add(base_val, index_val);

  always_comb begin
    res = '0;
    case (mode)
      AM_IMM: begin res.value = ext_field; res.mem = 1'b0; end
      AM_REG: begin res.value = base_val;  res.mem = 1'b0; end
      AM_ABS: begin res.value = ext_field; res.mem = 1'b1; end
      AM_IND: begin res.value = base_val;  res.mem = 1'b1; end
      AM_IDX: begin res.value = sum_off;   res.mem = 1'b1; end
      AM_BIX: begin res.value = sum_pair;  res.mem = 1'b1; end
      default: begin res.value = '0; res.mem = 1'b0; res.illegal = 1'b1; end
    endcase
    res.misalign = res.mem & low_bits_set(res.value);
  end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [MODE_W-1:0]  mode,
  input  logic [DATA_W-1:0]  base_val,
  input  logic [DATA_W-1:0]  index_val,
  input  logic [FIELD_W-1:0] ifield,
  output logic               out_valid,
  output logic [DATA_W-1:0]  result,
  output logic               mem_access,
  output logic               align_err,
  output logic               illegal_mode
);
  logic [DATA_W-1:0] ext_field, sum_off, sum_pair;
  ea_res_t           comb_res;
  ea_res_t           res_q;

  opaddr_calc u_calc (
    .mode      (mode),
    .base_val  (base_val),
    .index_val (index_val),
    .ifield    (ifield),
    .ext_field (ext_field),
    .sum_off   (sum_off),
    .sum_pair  (sum_pair),
    .res       (comb_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res_q <= comb_res;
    end
  end

  assign result       = res_q.value;
  assign mem_access   = res_q.mem;
  assign align_err    = res_q.misalign;
  assign illegal_mode = res_q.illegal;

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(mem_access) && $stable(align_err)
                  && $stable(illegal_mode));
  a_r7_align_needs_mem: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> mem_access && (result[1:0] != 2'b00));
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode |-> !mem_access && !align_err && result == '0);
  a_r6_pair_sum: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == AM_BIX |=> result == $past(base_val) + $past(index_val));
  a_r5_offset_sum: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == AM_IDX |=> result == $past(base_val) + $past(sext_field(ifield)));
  a_r1_imm_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == AM_IMM |=> !mem_access && !illegal_mode);
endmodule

// File: tb/sim_opaddr_gen.sv
module sim_opaddr_gen;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] base_val = '0, index_val = '0;
  logic [15:0] ifield = '0;
  logic        out_valid, mem_access, align_err, illegal_mode;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] v;
    bit mem;
    bit al;
    bit ill;
    string tag;
  } exp_t;
  exp_t sb[$];

  opaddr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .base_val(base_val), .index_val(index_val), .ifield(ifield),
    .out_valid(out_valid), .result(result), .mem_access(mem_access),
    .align_err(align_err), .illegal_mode(illegal_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ext16(input logic [15:0] f);
    return 32'($signed(f));
  endfunction

  // Driver: request on one cycle, expected value into the scoreboard.
  task automatic drive(input logic [2:0] m, input logic [31:0] b,
                       input logic [31:0] x, input logic [15:0] f, input string tag);
    exp_t e;
    e.tag = tag; e.ill = 0; e.mem = 0; e.v = 32'h0;
    if (m == 3'd0)      begin e.v = ext16(f); end                 // R1
    else if (m == 3'd1) begin e.v = b; end                        // R2
    else if (m == 3'd2) begin e.v = ext16(f); e.mem = 1; end      // R3
    else if (m == 3'd3) begin e.v = b; e.mem = 1; end             // R4
    else if (m == 3'd4) begin e.v = 32'(64'(b) + 64'(ext16(f))); e.mem = 1; end // R5
    else if (m == 3'd5) begin e.v = 32'(64'(b) + 64'(x)); e.mem = 1; end        // R6
    else                begin e.ill = 1; end                      // R8
    e.al = e.mem && (e.v % 4 != 0);                               // R7
    @(negedge clk);
    mode = m; base_val = b; index_val = x; ifield = f; in_valid = 1'b1;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare each produced result against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk("R9", "unexpected out_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "result", result, e.v);
        chk(e.tag, "mem_access", 32'(mem_access), 32'(e.mem));
        chk("R7", "align_err", 32'(align_err), 32'(e.al));
        chk("R8", "illegal_mode", 32'(illegal_mode), 32'(e.ill));
      end
    end
  end

  // R10: idle cycles with scrambled inputs leave the outputs untouched.
  task automatic idle_hold(input int n);
    logic [31:0] r0;
    logic [2:0] f0;
    @(negedge clk);
    r0 = result; f0 = {mem_access, align_err, illegal_mode};
    for (int i = 0; i < n; i++) begin
      mode = 3'(i); base_val = 32'h1357_9bdf ^ 32'(i); index_val = ~base_val;
      ifield = 16'(i * 777);
      @(negedge clk);
      chk("R10", "held result", result, r0);
      chk("R10", "held flags", 32'({mem_access, align_err, illegal_mode}), 32'(f0));
      chk("R9", "out_valid low when idle", 32'(out_valid), 32'd0);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset out_valid", 32'(out_valid), 32'd0);
    chk("R9", "reset result", result, 32'd0);
    chk("R9", "reset flags", 32'({mem_access, align_err, illegal_mode}), 32'd0);
    rst_n = 1'b1;

    drive(3'd0, 32'hdead_beef, 32'h0, 16'h7fff, "R1");
    drive(3'd0, 32'h0, 32'h0, 16'h8001, "R1");
    drive(3'd1, 32'h1234_5677, 32'h0, 16'hffff, "R2");
    drive(3'd2, 32'h0, 32'h0, 16'h8000, "R3");
    drive(3'd2, 32'h0, 32'h0, 16'h0102, "R3");
    drive(3'd3, 32'h0000_1003, 32'h0, 16'h0, "R4");
    drive(3'd3, 32'hffff_fff0, 32'h0, 16'h0, "R4");
    drive(3'd4, 32'h0000_2000, 32'h0, 16'hfffc, "R5");
    drive(3'd4, 32'hffff_fffe, 32'h0, 16'h0006, "R5");
    drive(3'd5, 32'h8000_0000, 32'h8000_0004, 16'h0, "R6");
    drive(3'd5, 32'h0000_0101, 32'h0000_0002, 16'h0, "R6");
    drive(3'd6, 32'hffff_ffff, 32'h1, 16'h1, "R8");
    drive(3'd7, 32'h3, 32'h3, 16'h3, "R8");
    idle_hold(4);
    drive(3'd4, 32'h0000_0010, 32'h0, 16'h0001, "R5");
    idle_hold(3);
    // back-to-back requests
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      exp_t e;
      logic [31:0] b = 32'h100 * 32'(i + 1) + 32'(i);
      logic [31:0] x = 32'(i * 4);
      mode = 3'd5; base_val = b; index_val = x; in_valid = 1'b1;
      e.v = b + x; e.mem = 1; e.ill = 0; e.al = ((b + x) % 4) != 0; e.tag = "R6";
      sb.push_back(e);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "scoreboard drained", 32'(sb.size()), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule